// File: doc/BRIEF.md
# Square Channel Pitch Sweep Controller

This block moves the pitch of a square-wave tone channel up or down on its own at a fixed rate. It keeps a private copy of the 11-bit channel frequency, a small countdown timer that is advanced by a slow tick from the frame sequencer (128 Hz in the intended system), and an internal enable flag. On each timer expiry it computes a new frequency. The new frequency is the private copy plus, or minus, the copy shifted right by a programmable amount. If the result is still in range, the block writes it back to the channel through a one-cycle strobe.

A trigger pulse restarts the unit. The trigger copies the present channel frequency into the private copy, reloads the timer and may run an immediate range check. When a computed frequency goes above 2047, or when software switches from decrease to increase mode after a decreasing calculation, the block emits a one-cycle pulse that silences the channel. The settings arrive as live fields of a configuration register: period, direction and shift. All outputs are registered, so each appears one clock after the edge at which its cause was sampled.

Top module: `sweep_unit`

## Requirements
- R1: On `trig`, the private copy loads `chan_freq` and the timer reloads with the period (a period of 0 reloads as 8). The cycle after a trigger never carries a `wr_en` strobe.
- R2: On `trig`, the enable flag is set when `cfg_period` or `cfg_shift` is non-zero. When both are zero, the flag is cleared and later ticks produce neither `wr_en` nor `kill`.
- R3: On `trig` with a non-zero `cfg_shift`, one calculation runs on `chan_freq` at once. `kill` pulses on the next cycle if the result exceeds 2047. With a shift of 0, no check runs at trigger.
- R4: A calculation returns F + (F >> shift) when `cfg_down` is 0, and F − (F >> shift) when `cfg_down` is 1, where F is the value the calculation starts from.
- R5: The timer decrements on each `tick`. On the tick that finds it at 1, it reloads and fires. Once triggered, the unit fires on every P-th tick, where P is the period and 0 counts as 8. A firing with the flag set and a non-zero period runs a calculation from the private copy, and `kill` pulses on the next cycle if the result exceeds 2047.
- R6: If that result is at most 2047 and `cfg_shift` is non-zero, it goes into the private copy and appears on `wr_freq` with a one-cycle `wr_en` on the next cycle. A second calculation is then run from the new value and is not written back. If it exceeds 2047, `kill` pulses in the same cycle as the strobe.
- R7: With `cfg_shift` equal to 0, a firing never writes back, but the overflow check still runs; the result then is 2F, or 0 in decrease mode.
- R8: With `cfg_period` equal to 0, a firing performs no calculation, even if the flag is set.
- R9: If a calculation in decrease mode has run since the last trigger, then `cfg_down` at 0 in a cycle without `trig` gives one `kill` pulse on the next cycle. The condition is then cleared.
- R10: Changes on `chan_freq` between triggers do not affect the private copy; later write-backs continue from the copy.
- R11: During and right after reset, `wr_en` and `kill` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 3 | Sweep period in ticks (0 means 8 and no calculation) |
| cfg_down | input | 1 | 1 = decrease frequency, 0 = increase |
| cfg_shift | input | 3 | Right-shift amount used in the calculation |
| chan_freq | input | 11 | Current channel frequency |
| trig | input | 1 | Channel trigger pulse |
| tick | input | 1 | Slow sweep tick from the frame sequencer |
| wr_en | output | 1 | One-cycle strobe: write `wr_freq` to the channel |
| wr_freq | output | 11 | Frequency value written back |
| kill | output | 1 | One-cycle pulse that disables the channel |

## Verification
The bench builds the block with its default widths: an 11-bit frequency and 3-bit period and shift fields. With these widths, the 2047 overflow boundary, the 0-as-8 period reload and the maximum shift of 7 can all be reached with short tick sequences. Ticks are spaced a few cycles apart in most runs and issued back to back in some, so timer expiry can coincide with a register change. A cycle-level integer model predicts every strobe, value and disable pulse.

// File: rtl/sweep_unit.sv
module sweep_unit #(
  parameter int FW = 11,
  parameter int PW = 3,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_period,
  input  logic          cfg_down,
  input  logic [SW-1:0] cfg_shift,
  input  logic [FW-1:0] chan_freq,
  input  logic          trig,
  input  logic          tick,
  output logic          wr_en,
  output logic [FW-1:0] wr_freq,
  output logic          kill
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << PW;

  function automatic logic [FW:0] step(input logic [FW-1:0] f, input logic [SW-1:0] s, input logic dn);
    logic [FW:0] d;
    d = {1'b0, f >> s};
    return dn ? ({1'b0, f} - d) : ({1'b0, f} + d);
  endfunction

  logic [FW-1:0] shadow;
  logic [CW-1:0] cnt;
  logic          en, neg_used;

  wire [CW-1:0] reload   = (cfg_period == '0) ? FULL : {1'b0, cfg_period};
  wire          fire     = tick && (cnt == CW'(1));
  wire          act      = fire && en && (cfg_period != '0);
  wire [FW:0]   n1       = step(trig ? chan_freq : shadow, cfg_shift, cfg_down);
  wire [FW:0]   n2       = step(n1[FW-1:0], cfg_shift, cfg_down);
  wire          shift_nz = (cfg_shift != '0);
  wire          neg_kill = neg_used && !cfg_down && !trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow   <= '0;
      cnt      <= FULL;
      en       <= 1'b0;
      neg_used <= 1'b0;
      wr_en    <= 1'b0;
      wr_freq  <= '0;
      kill     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      kill  <= 1'b0;
      if (trig) begin
        shadow   <= chan_freq;
        cnt      <= reload;
        en       <= (cfg_period != '0) || shift_nz;
        neg_used <= shift_nz && cfg_down;
        kill     <= shift_nz && n1[FW];
      end else begin
        kill <= neg_kill;
        if (neg_kill) neg_used <= 1'b0;
        if (tick) cnt <= fire ? reload : cnt - CW'(1);
        if (act) begin
          if (cfg_down) neg_used <= 1'b1;
          if (n1[FW]) kill <= 1'b1;
          else if (shift_nz) begin
            shadow  <= n1[FW-1:0];
            wr_en   <= 1'b1;
            wr_freq <= n1[FW-1:0];
            if (n2[FW]) kill <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module sweep_unit_chk #(
  parameter int PW = 3,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] cfg_period,
  input logic [SW-1:0] cfg_shift,
  input logic          trig,
  input logic          tick,
  input logic          wr_en,
  input logic          kill
);
  // R1
  trig_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !wr_en);
  // R5
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(tick));
  // R7
  strobe_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cfg_shift) != '0);
  // R8
  strobe_needs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cfg_period) != '0);
  // R2
  idle_trig_nokill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_period == '0 && cfg_shift == '0) |=> !kill);
  // R11
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!wr_en && !kill || $isunknown(wr_en));
endmodule

bind sweep_unit sweep_unit_chk #(.PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_shift(cfg_shift),
  .trig(trig), .tick(tick), .wr_en(wr_en), .kill(kill)
);

// File: tb/tb_sweep_unit.sv
module tb_sweep_unit;
  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_period = 0, cfg_shift = 0;
  logic cfg_down = 0, trig = 0, tick = 0;
  logic [10:0] chan_freq = 0;
  logic wr_en, kill;
  logic [10:0] wr_freq;

  sweep_unit dut (.clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_down(cfg_down),
    .cfg_shift(cfg_shift), .chan_freq(chan_freq), .trig(trig), .tick(tick),
    .wr_en(wr_en), .wr_freq(wr_freq), .kill(kill));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string scen = "R11", tag;
  int m_shadow, m_cnt, m_wr_val;
  bit m_en, m_neg, e_wr, e_kill;

  function automatic int calc(int f, int s, bit dn);
    return dn ? f - (f >> s) : f + (f >> s);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int n, r;
    cyc++;
    e_wr = 0; e_kill = 0; tag = scen;
    r = (cfg_period == 0) ? 8 : cfg_period;
    if (!rst_n) begin
      m_shadow = 0; m_cnt = 8; m_en = 0; m_neg = 0;
    end else if (trig) begin
      m_shadow = chan_freq; m_cnt = r;
      m_en = (cfg_period != 0) || (cfg_shift != 0);
      m_neg = 0;
      if (cfg_shift != 0) begin
        if (cfg_down) m_neg = 1;
        if (calc(chan_freq, cfg_shift, cfg_down) > 2047) begin e_kill = 1; tag = "R3"; end
      end
    end else begin
      if (m_neg && !cfg_down) begin e_kill = 1; m_neg = 0; tag = "R9"; end
      if (tick) begin
        if (m_cnt == 1) begin
          m_cnt = r;
          if (m_en && cfg_period != 0) begin
            if (cfg_down) m_neg = 1;
            n = calc(m_shadow, cfg_shift, cfg_down);
            if (n > 2047) begin e_kill = 1; tag = "R5"; end
            else if (cfg_shift != 0) begin
              m_shadow = n; e_wr = 1; m_wr_val = n; tag = "R6";
              if (calc(n, cfg_shift, cfg_down) > 2047) e_kill = 1;
            end
          end
        end else m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    check(tag, wr_en, e_wr, "wr_en");
    check(tag, kill, e_kill, "kill");
    if (e_wr) check("R4", wr_freq, m_wr_val, "wr_freq");
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic go(int per, bit dn, int sh, int f);
    @(negedge clk);
    cfg_period = per[2:0]; cfg_down = dn; cfg_shift = sh[2:0]; chan_freq = f[10:0];
    trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    scen = "R11";
    repeat (3) @(negedge clk);
    check("R11", wr_en, 0, "reset wr_en");
    check("R11", kill, 0, "reset kill");
    rst_n = 1;
    repeat (2) @(negedge clk);
    scen = "R5";  go(2, 0, 1, 'h100); ticks(14, 2);
    scen = "R3";  go(3, 0, 1, 'h700); ticks(4, 1);
    scen = "R3";  go(0, 0, 0, 'h7FF); ticks(2, 0);
    scen = "R2";  go(0, 0, 0, 'h400); ticks(20, 1);
    scen = "R7";  go(3, 0, 0, 'h300); ticks(7, 1);
    scen = "R7";  go(3, 0, 0, 'h500); ticks(4, 1);
    scen = "R1";  go(0, 0, 3, 'h200); ticks(18, 0);
    scen = "R8";  go(0, 1, 7, 'h7FF); ticks(18, 2);
    scen = "R10"; go(1, 0, 2, 'h200); ticks(1, 2);
    @(negedge clk) chan_freq = 'h050;
    ticks(3, 2);
    scen = "R9";  go(1, 1, 2, 'h400); ticks(3, 2);
    @(negedge clk) cfg_down = 0;
    repeat (4) @(negedge clk);
    cfg_shift = 0;
    ticks(3, 1);
    scen = "R9";  go(2, 1, 0, 'h100); ticks(2, 1);
    @(negedge clk) cfg_down = 0;
    repeat (3) @(negedge clk);
    scen = "R6";  go(4, 1, 1, 'h7FF); ticks(30, 0);
    scen = "R5";  go(1, 0, 7, 'h7F8); ticks(6, 3);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule